// File: doc/BRIEF.md
# Triple-Buffer Display Flip Controller

This block coordinates three colour frame buffers that live in main memory, shared between a renderer and a display scan-out engine. It tells the renderer which buffer base address to draw into next, remembers which buffer carries the newest completed frame, and at a permitted flip point moves the scan-out base pointer onto that frame. A flip changes nothing but a pointer; no pixel data moves.

The three base addresses are programmed through a small write port while the controller is held in reset. After reset the renderer starts on the first buffer and the display shows blank frames until the first completed frame is flipped in. The flip point is the vertical-blank strobe when vsync is enabled, and the horizontal-blank strobe when it is disabled. A flip point that finds no new frame repeats the current buffer. A renderer that completes a frame while a finished frame is still queued is stalled until the next flip frees a buffer. Each buffer is sized for a 32-bit-per-pixel frame (1280x720x4 bytes at HD), and the programmed bases are expected to be spaced by at least that amount plus alignment.

Top module: `tribuf_flip_ctrl`

## Requirements
- R1: `cfg_we` writes `cfg_addr` into base register `cfg_idx` (0, 1, 2 name buffers A, B, C) only on a clock edge where `rst` is high; index 3 and any write while `rst` is low have no effect on the addresses the block outputs.
- R2: In the cycle after reset is released, `render_addr` equals the base of buffer A, `disp_valid` is 0, `disp_addr` is 0, and `stall`, `flip_done` and `repeat_flip` are 0.
- R3: Each accepted `render_done` moves `render_addr` to the next buffer in the order A, B, C, A, taking effect in the cycle after the strobe.
- R4: The flip point is `vblank` when `vsync_en` is 1 and `hblank` when `vsync_en` is 0; the other strobe has no effect on the display pointer or the pulses.
- R5: At a flip point with a completed frame queued, `disp_addr` becomes that frame's base, `disp_valid` becomes 1 and `flip_done` pulses for exactly one cycle, all in the cycle after the strobe.
- R6: At a flip point with no queued frame, `disp_addr` and `disp_valid` are unchanged and `repeat_flip` pulses for one cycle; `flip_done` and `repeat_flip` are never high together.
- R7: A `render_done` that arrives while a completed frame is already queued (and not removed by a flip in the same cycle) raises `stall` in the next cycle; while `stall` is high `render_addr` holds and further `render_done` strobes are ignored.
- R8: A flip while `stall` is high queues the stalled frame, clears `stall` and advances `render_addr` to the buffer that the flip released, all in the cycle after the strobe; `stall` never falls without a flip point in the preceding cycle.
- R9: While `disp_valid` is 1, `render_addr` never equals `disp_addr`.
- R10: When a flip point and `render_done` coincide with a frame queued and no stall, the queued frame is displayed and the just-finished frame becomes the queued one without stalling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; base writes allowed only while high |
| cfg_we | input | 1 | Base register write enable |
| cfg_idx | input | 2 | Base register index (0=A, 1=B, 2=C) |
| cfg_addr | input | AW | Base address to write |
| vsync_en | input | 1 | 1: flip on vblank, 0: flip on hblank |
| vblank | input | 1 | Vertical blank strobe |
| hblank | input | 1 | Horizontal blank strobe |
| render_done | input | 1 | Renderer finished its current frame |
| render_addr | output | AW | Base address of the buffer the renderer must draw into |
| disp_addr | output | AW | Scan-out base address (0 while blank) |
| disp_valid | output | 1 | A completed frame is being displayed |
| stall | output | 1 | Renderer must wait for a flip |
| flip_done | output | 1 | One-cycle pulse per actual pointer change |
| repeat_flip | output | 1 | One-cycle pulse per flip point that found no new frame |

## Verification
The bench targets the coincidences: a flip point and render completion in the same cycle, a completion during a stall, the unused blank strobe under each vsync setting, and base writes outside reset. A design that ordered flip and completion the wrong way would stall when it should not or display a stale buffer; one that accepted completions during a stall would skip a buffer in the rotation and could render into the scanned-out buffer. Mixing up the two strobes would show frames mid-scan, and letting writes through outside reset would jump the render target to a stray address.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
  localparam int NBUF = 3;
  localparam int IW   = $clog2(NBUF);
  typedef logic [IW-1:0] buf_idx_t;

  function automatic buf_idx_t next_idx(input buf_idx_t i);
    if (i == buf_idx_t'(NBUF - 1)) return '0;
    return i + 1'b1;
  endfunction
endpackage

// File: rtl/tbf_base_regs.sv
module tbf_base_regs
  import tbf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  buf_idx_t      widx,
  input  logic [AW-1:0] wdata,
  input  buf_idx_t      ren_idx,
  input  buf_idx_t      disp_idx,
  output logic [AW-1:0] ren_base,
  output logic [AW-1:0] disp_base
);
  logic [AW-1:0] mem [NBUF];

  // Small distributed RAM; writes accepted only during reset
  always_ff @(posedge clk) begin
    if (rst && we && (int'(widx) < NBUF)) mem[widx] <= wdata;
  end

  assign ren_base  = mem[ren_idx];
  assign disp_base = mem[disp_idx];

  for (genvar g = 0; g < NBUF; g++) begin : g_hold
    assert_base_frozen_R1: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(mem[g]));
  end
endmodule

// File: rtl/tbf_seq.sv
module tbf_seq
  import tbf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     vsync_en,
  input  logic     vblank,
  input  logic     hblank,
  input  logic     render_done,
  output buf_idx_t ren_idx,
  output buf_idx_t disp_idx,
  output logic     have_disp,
  output logic     stall,
  output logic     flip_done,
  output logic     repeat_flip
);
  buf_idx_t ren_q, q_q, d_q;
  logic     have_q, have_d, stall_q, flip_q, rep_q;

  buf_idx_t n_ren, n_q, n_d;
  logic     n_have_q, n_have_d, n_stall;
  logic     fpoint, do_flip;

  assign fpoint  = vsync_en ? vblank : hblank;
  assign do_flip = fpoint && have_q;

  always_comb begin
    n_ren    = ren_q;
    n_q      = q_q;
    n_d      = d_q;
    n_have_q = have_q;
    n_have_d = have_d;
    n_stall  = stall_q;
    // flip uses the queued frame present at the start of the cycle
    if (do_flip) begin
      n_d      = q_q;
      n_have_d = 1'b1;
      n_have_q = 1'b0;
      if (stall_q) begin
        n_q      = ren_q;
        n_have_q = 1'b1;
        n_ren    = next_idx(ren_q);
        n_stall  = 1'b0;
      end
    end
    // completion is accepted only when not stalled at the start of the cycle
    if (render_done && !stall_q) begin
      if (n_have_q) begin
        n_stall = 1'b1;
      end else begin
        n_q      = ren_q;
        n_have_q = 1'b1;
        n_ren    = next_idx(ren_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ren_q   <= '0;
      q_q     <= '0;
      d_q     <= '0;
      have_q  <= 1'b0;
      have_d  <= 1'b0;
      stall_q <= 1'b0;
      flip_q  <= 1'b0;
      rep_q   <= 1'b0;
    end else begin
      ren_q   <= n_ren;
      q_q     <= n_q;
      d_q     <= n_d;
      have_q  <= n_have_q;
      have_d  <= n_have_d;
      stall_q <= n_stall;
      flip_q  <= do_flip;
      rep_q   <= fpoint && !have_q;
    end
  end

  assign ren_idx     = ren_q;
  assign disp_idx    = d_q;
  assign have_disp   = have_d;
  assign stall       = stall_q;
  assign flip_done   = flip_q;
  assign repeat_flip = rep_q;

  assert_no_render_on_disp_R9: assert property (@(posedge clk) disable iff (rst)
    have_d |-> (d_q != ren_q));
  assert_queue_distinct_R9: assert property (@(posedge clk) disable iff (rst)
    have_q |-> (q_q != ren_q) && (!have_d || q_q != d_q));
  assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(flip_q && rep_q));
  assert_disp_moves_on_fpoint_R4: assert property (@(posedge clk) disable iff (rst)
    !fpoint |=> $stable(d_q) && !flip_q && !rep_q);
  assert_stall_clears_on_flip_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_q) |-> $past(fpoint));
  assert_render_held_in_stall_R7: assert property (@(posedge clk) disable iff (rst)
    stall_q && !fpoint |=> $stable(ren_q));
endmodule

// File: rtl/tribuf_flip_ctrl.sv
module tribuf_flip_ctrl
  import tbf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_idx,
  input  logic [AW-1:0] cfg_addr,
  input  logic          vsync_en,
  input  logic          vblank,
  input  logic          hblank,
  input  logic          render_done,
  output logic [AW-1:0] render_addr,
  output logic [AW-1:0] disp_addr,
  output logic          disp_valid,
  output logic          stall,
  output logic          flip_done,
  output logic          repeat_flip
);
  buf_idx_t      ren_idx, disp_idx;
  logic          have_disp;
  logic [AW-1:0] ren_base, disp_base;

  tbf_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .vsync_en    (vsync_en),
    .vblank      (vblank),
    .hblank      (hblank),
    .render_done (render_done),
    .ren_idx     (ren_idx),
    .disp_idx    (disp_idx),
    .have_disp   (have_disp),
    .stall       (stall),
    .flip_done   (flip_done),
    .repeat_flip (repeat_flip)
  );

  tbf_base_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .widx      (buf_idx_t'(cfg_idx)),
    .wdata     (cfg_addr),
    .ren_idx   (ren_idx),
    .disp_idx  (disp_idx),
    .ren_base  (ren_base),
    .disp_base (disp_base)
  );

  // outputs are a select of registered state and registered bases
  assign render_addr = ren_base;
  assign disp_addr   = have_disp ? disp_base : '0;
  assign disp_valid  = have_disp;

  assert_flip_changes_ptr_R5: assert property (@(posedge clk) disable iff (rst)
    flip_done |-> disp_valid);
  assert_blank_until_flip_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_valid) |-> flip_done);
endmodule

// File: tb/sim_tribuf_flip_ctrl.sv
module sim_tribuf_flip_ctrl;
  localparam int PERIOD = 10;
  localparam int AW     = 32;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic          rst = 1'b1, cfg_we = 1'b0, vsync_en = 1'b1;
  logic          vblank = 1'b0, hblank = 1'b0, render_done = 1'b0;
  logic [1:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [AW-1:0] render_addr, disp_addr;
  logic          disp_valid, stall, flip_done, repeat_flip;

  tribuf_flip_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
    .vsync_en(vsync_en), .vblank(vblank), .hblank(hblank), .render_done(render_done),
    .render_addr(render_addr), .disp_addr(disp_addr), .disp_valid(disp_valid),
    .stall(stall), .flip_done(flip_done), .repeat_flip(repeat_flip)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // behavioural reference: -1 means "none"
  logic [AW-1:0] m_base [3];
  int m_ren = 0, m_q = -1, m_d = -1;
  bit m_stl = 0, m_fd = 0, m_rp = 0;

  always @(posedge clk) begin
    bit fp, was_stl;
    if (rst) begin
      if (cfg_we && cfg_idx != 2'd3) m_base[cfg_idx] = cfg_addr;
      m_ren = 0; m_q = -1; m_d = -1; m_stl = 0; m_fd = 0; m_rp = 0;
    end else begin
      fp = vsync_en ? vblank : hblank;
      was_stl = m_stl;
      m_fd = 0; m_rp = 0;
      if (fp) begin
        if (m_q >= 0) begin
          m_d = m_q; m_q = -1; m_fd = 1;
          if (was_stl) begin m_q = m_ren; m_ren = (m_ren + 1) % 3; m_stl = 0; end
        end else m_rp = 1;
      end
      if (render_done && !was_stl) begin
        if (m_q >= 0) m_stl = 1;
        else begin m_q = m_ren; m_ren = (m_ren + 1) % 3; end
      end
    end
  end

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R3 render_addr", render_addr, m_base[m_ren]);
    chk("R5 disp_addr", disp_addr, (m_d >= 0) ? m_base[m_d] : '0);
    chk("R5 disp_valid", AW'(disp_valid), AW'(m_d >= 0));
    chk("R7 stall", AW'(stall), AW'(m_stl));
    chk("R5 flip_done", AW'(flip_done), AW'(m_fd));
    chk("R6 repeat_flip", AW'(repeat_flip), AW'(m_rp));
    if (disp_valid) chk("R9 render!=disp", AW'(render_addr == disp_addr), '0);
  endtask

  // apply inputs at a falling edge, compare at the next falling edge
  task automatic cyc(input bit vb, input bit hb, input bit dn);
    vblank = vb; hblank = hb; render_done = dn;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input logic [AW-1:0] b0);
    rst = 1'b1; vblank = 0; hblank = 0; render_done = 0;
    for (int i = 0; i < 4; i++) begin
      cfg_we = 1'b1; cfg_idx = 2'(i);
      cfg_addr = (i == 3) ? 32'hDEAD_0000 : b0 + AW'(i) * 32'h0040_0000;
      @(negedge clk);
    end
    cfg_we = 1'b0; @(negedge clk);
    rst = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(32'h1000_0000);
    // R2: reset state against literal values
    chk("R2 render_addr", render_addr, 32'h1000_0000);
    chk("R2 disp_valid", AW'(disp_valid), '0);
    chk("R2 disp_addr", disp_addr, '0);
    chk("R2 stall", AW'(stall), '0);
    chk("R2 pulses", AW'({flip_done, repeat_flip}), '0);
    compare();
    // R1: write outside reset must not change buffer A's base
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_addr = 32'h7777_0000;
    cyc(0, 0, 0);
    cfg_we = 1'b0;
    chk("R1 base A kept", render_addr, 32'h1000_0000);
    // R6: flip point before any frame repeats blank
    cyc(1, 0, 0);
    chk("R6 repeat blank", AW'(repeat_flip), 1);
    // R3: A done -> B
    cyc(0, 0, 1);
    chk("R3 render B", render_addr, 32'h1040_0000);
    // R4: hblank ignored with vsync on
    cyc(0, 1, 0);
    chk("R4 hblank ignored", AW'(disp_valid), '0);
    // R5: vblank flips A in
    cyc(1, 0, 0);
    chk("R5 disp A", disp_addr, 32'h1000_0000);
    chk("R5 flip pulse", AW'(flip_done), 1);
    cyc(0, 0, 0);
    chk("R5 one cycle", AW'(flip_done), '0);
    // R7: B done, C rendering; C done while B queued -> stall
    cyc(0, 0, 1);
    cyc(0, 0, 1);
    chk("R7 stall high", AW'(stall), 1);
    cyc(0, 0, 1);
    chk("R7 done ignored", render_addr, 32'h1080_0000);
    // R8: flip releases A; stalled C queued, render A
    cyc(1, 0, 0);
    chk("R8 stall cleared", AW'(stall), '0);
    chk("R8 render A", render_addr, 32'h1000_0000);
    chk("R8 disp B", disp_addr, 32'h1040_0000);
    // R10: flip and done together, no stall
    cyc(1, 0, 1);
    chk("R10 disp C", disp_addr, 32'h1080_0000);
    chk("R10 no stall", AW'(stall), '0);
    chk("R10 render B", render_addr, 32'h1040_0000);
    // R4: vsync off -> hblank flips, vblank ignored
    vsync_en = 1'b0;
    cyc(1, 0, 0);
    chk("R4 vblank ignored", disp_addr, 32'h1080_0000);
    cyc(0, 1, 0);
    chk("R4 hblank flips", disp_addr, 32'h1000_0000);
    // random traffic, including stray writes outside reset
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) vsync_en = $urandom_range(0, 1);
      cfg_we = ($urandom_range(0, 15) == 0); cfg_idx = 2'($urandom_range(0, 3));
      cfg_addr = $urandom;
      cyc($urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0);
      if (n == 2000) begin cfg_we = 0; do_reset(32'h2000_0000); compare(); end
    end
    cfg_we = 1'b0;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule